// File: doc/BRIEF.md
# Glitchless clock select and enable controller

This block is the output stage of a clock source that can produce several frequencies. A pin sensing circuit reduces a multi-level select pin to a two-bit level code: strong high, weak high, weak low or strong low. Other logic produces a free-running candidate clock for each frequency. The block maps the level to an action, passes exactly one candidate to the output through glitch-free gates, and drives the enable of the output tri-state driver. It also reports which low-power mode the source is in, through three power-down flags and a mode code.

Two build-time variants exist. In the two-frequency variant, the two high levels choose a frequency and either low level turns the output off. Turning the output off puts the source into one low-power mode fixed by a parameter. Stop keeps everything running except the output driver. Doze also stops the oscillator side. Sleep leaves only configuration retention. Each mode has its own resume delay, counted on a free-running control clock. In the four-frequency variant, each level chooses one of four frequencies and the output is never turned off.

Every transition ends only at clock-low phases. A gate opens or closes only while its own source clock is low, and the driver enable falls only after the last gate has closed. While a transition is pending, a busy flag is high and the pin is ignored. There is one special case: a selection change made while in Stop resumes first on the previous frequency, and then switches.

Top module: `clksel_ctrl`

## Requirements
- R1: `pin_lvl` encodes 2'b11 strong high, 2'b10 weak high, 2'b01 weak low and 2'b00 strong low. With FREQS=2, 2'b11 gives `sel_o`=0 and 2'b10 gives `sel_o`=1. Either low level turns the output off into the build-time mode LOW_MODE.
- R2: With FREQS=4, 2'b11, 2'b10, 2'b01 and 2'b00 give `sel_o` 0, 1, 2 and 3. Once started, `oe_o` never falls and `mode_o` stays 0.
- R3: During and after reset, the outputs are `oe_o`=0, `busy_o`=0, `mode_o`=3, `pd_o`=3'b111 and `sel_o`=1. The first control edge that samples an enabling level starts a resume of SLEEP_DLY, and `oe_o` rises on the (SLEEP_DLY+1)-th edge after that sampling edge. A weak-high start selects `sel_o`=1.
- R4: `clk_o` is low whenever `oe_o` is low. `oe_o` falls only after every gate has closed. Every high and every low phase of `clk_o` lasts at least half a period of a source clock, so no runt pulse appears.
- R5: Stop gives `mode_o`=1 and `pd_o`=3'b001. In `pd_o`, bit 0 means the driver is off, bit 1 the oscillator is off and bit 2 the core is off. Resuming from Stop raises `oe_o` on the (STOP_DLY+1)-th edge after the sampling edge.
- R6: Doze gives `mode_o`=2, `pd_o`=3'b011 and a resume of DOZE_DLY+1 edges. Sleep gives `mode_o`=3, `pd_o`=3'b111 and a resume of SLEEP_DLY+1 edges. During a resume, both fields keep their off values, and they become 0 on the edge where `oe_o` rises.
- R7: If the selection changed while in Stop, the output resumes on the previous frequency (`sel_o` still holds the old index when `oe_o` rises). A glitch-free switch to the new frequency follows.
- R8: A resume from Doze or Sleep comes back directly at the newly selected frequency: `sel_o` already holds the new index when `oe_o` rises.
- R9: A selection change while running proceeds in order. `busy_o` rises. The old gate closes before any other gate opens. `sel_o` takes the new index and `clk_o` runs at the new frequency. `busy_o` falls UPD_DLY+1 edges after the new gate is confirmed, so every transition ends within a bounded time.
- R10: Changes of `pin_lvl` while `busy_o` is high have no effect. `sel_o` changes only while a transition is in progress.
- R11: While `oe_o` is high, `pd_o` is 3'b000 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 2 | Decoded select-pin level code |
| src_clk | input | FREQS | Candidate clocks, index 0 = frequency 1 |
| clk_o | output | 1 | Gated output clock |
| oe_o | output | 1 | Enable for the output tri-state driver |
| pd_o | output | 3 | Power-down flags: driver, oscillator, core |
| mode_o | output | 2 | 0 run, 1 stop, 2 doze, 3 sleep |
| sel_o | output | 2 | Index of the clock currently routed |
| busy_o | output | 1 | Transition in progress, pin ignored |

## Verification
The assertions assume that every candidate clock keeps toggling while reset is released and afterwards, because the gate handshake depends on edges of each source. They also assume that `pin_lvl` is a clean level code that changes on the control clock, not in the middle of a control edge. The stimulus changes the level only at falling control edges. Apart from one deliberate test of the ignore rule, it holds each level until all instances report idle, so each request stays stable for the whole event it started.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

  // low-power state reported on mode_o
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_STOP  = 2'd1,
    PM_DOZE  = 2'd2,
    PM_SLEEP = 2'd3
  } pmode_e;

  // action requested by one pin level
  typedef struct packed {
    logic       on;
    logic [1:0] sel;
  } lvl_req_t;

  // level code: 3 strong high, 2 weak high, 1 weak low, 0 strong low
  function automatic lvl_req_t decode_level(input logic [1:0] lvl, input logic quad);
    lvl_req_t r;
    if (quad) begin
      r.on  = 1'b1;
      r.sel = 2'd3 - lvl;
    end else begin
      r.on  = lvl[1];
      r.sel = {1'b0, ~lvl[0]};
    end
    return r;
  endfunction

  // {core_off, osc_off, drv_off}
  function automatic logic [2:0] power_flags(input pmode_e m);
    case (m)
      PM_STOP:  return 3'b001;
      PM_DOZE:  return 3'b011;
      PM_SLEEP: return 3'b111;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic int resume_cycles(input pmode_e m, input int d_stop,
                                       input int d_doze, input int d_sleep);
    case (m)
      PM_STOP: return d_stop;
      PM_DOZE: return d_doze;
      default: return d_sleep;
    endcase
  endfunction

endpackage

// File: rtl/clk_sync.sv
`timescale 1ns/1ps
module clk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_req,
  output logic gate_q,
  output logic gclk
);
  logic en_s;

  clk_sync u_sync (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d     (en_req),
    .q     (en_s)
  );

  // gate changes only while the source is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_s;
  end

  assign gclk = clk_src & gate_q;
endmodule

// File: rtl/clksel_fsm.sv
`timescale 1ns/1ps
module clksel_fsm
  import clksel_pkg::*;
#(
  parameter int     FREQS     = 2,
  parameter pmode_e LOW_MODE  = PM_STOP,
  parameter int     STOP_DLY  = 2,
  parameter int     DOZE_DLY  = 40,
  parameter int     SLEEP_DLY = 80,
  parameter int     UPD_DLY   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pin_lvl,
  input  logic [FREQS-1:0] ack_v,
  output logic [FREQS-1:0] en_req,
  output logic             oe,
  output pmode_e           mode,
  output logic [1:0]       sel,
  output logic             busy
);
  localparam logic QUAD = (FREQS == 4);
  localparam int   MAXA = (STOP_DLY > DOZE_DLY) ? STOP_DLY : DOZE_DLY;
  localparam int   MAXB = (SLEEP_DLY > UPD_DLY) ? SLEEP_DLY : UPD_DLY;
  localparam int   MAXD = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int   CW   = $clog2(MAXD + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_WAKE, S_WAKE_ON, S_RUN, S_SW_OFF, S_SW_ON, S_SETTLE, S_HALT
  } st_e;

  st_e           st_q;
  logic [1:0]    tgt_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  lvl_req_t      req;
  logic          ack_cur;
  logic          all_closed;

  function automatic logic [FREQS-1:0] onehot(input logic [1:0] s);
    logic [FREQS-1:0] v;
    for (int i = 0; i < FREQS; i++) v[i] = (s == 2'(i));
    return v;
  endfunction

  assign req        = decode_level(pin_lvl, QUAD);
  assign ack_cur    = |(ack_v & onehot(sel));
  assign all_closed = ~|ack_v;
  assign busy       = !(st_q == S_IDLE || st_q == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sel    <= 2'd1;
      tgt_q  <= 2'd1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      en_req <= '0;
      oe     <= 1'b0;
      mode   <= PM_SLEEP;
    end else begin
      case (st_q)
        S_IDLE: if (req.on) begin
          cnt_q <= CW'(resume_cycles(mode, STOP_DLY, DOZE_DLY, SLEEP_DLY));
          tgt_q <= req.sel;
          if (mode == PM_STOP && req.sel != sel) pend_q <= 1'b1;
          else                                   sel    <= req.sel;
          st_q <= S_WAKE;
        end
        S_WAKE: begin
          if (cnt_q == '0) begin
            oe     <= 1'b1;
            mode   <= PM_RUN;
            en_req <= onehot(sel);
            st_q   <= S_WAKE_ON;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_WAKE_ON: if (ack_cur) begin
          if (pend_q) begin
            en_req <= '0;
            st_q   <= S_SW_OFF;
          end else begin
            st_q <= S_RUN;
          end
        end
        S_RUN: begin
          if (!req.on) begin
            en_req <= '0;
            st_q   <= S_HALT;
          end else if (req.sel != sel) begin
            tgt_q  <= req.sel;
            en_req <= '0;
            st_q   <= S_SW_OFF;
          end
        end
        S_SW_OFF: if (all_closed) begin
          sel    <= tgt_q;
          en_req <= onehot(tgt_q);
          st_q   <= S_SW_ON;
        end
        S_SW_ON: if (ack_cur) begin
          cnt_q <= CW'(UPD_DLY);
          st_q  <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt_q == '0) begin
            pend_q <= 1'b0;
            st_q   <= S_RUN;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_HALT: if (all_closed) begin
          oe   <= 1'b0;
          mode <= LOW_MODE;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int     FREQS     = 2,
  parameter pmode_e LOW_MODE  = PM_STOP,
  parameter int     STOP_DLY  = 2,
  parameter int     DOZE_DLY  = 40,
  parameter int     SLEEP_DLY = 80,
  parameter int     UPD_DLY   = 8
) (
  input  logic             clk_ctl,
  input  logic             rst_n,
  input  logic [1:0]       pin_lvl,
  input  logic [FREQS-1:0] src_clk,
  output logic             clk_o,
  output logic             oe_o,
  output logic [2:0]       pd_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       sel_o,
  output logic             busy_o
);
  logic [FREQS-1:0] en_req;
  logic [FREQS-1:0] gate_on;
  logic [FREQS-1:0] gclk_v;
  logic [FREQS-1:0] ack_v;
  pmode_e           mode_q;

  for (genvar i = 0; i < FREQS; i++) begin : g_lane
    clk_gate_cell u_gate (
      .clk_src (src_clk[i]),
      .rst_n   (rst_n),
      .en_req  (en_req[i]),
      .gate_q  (gate_on[i]),
      .gclk    (gclk_v[i])
    );
    clk_sync u_ack (
      .clk   (clk_ctl),
      .rst_n (rst_n),
      .d     (gate_on[i]),
      .q     (ack_v[i])
    );
  end

  clksel_fsm #(
    .FREQS     (FREQS),
    .LOW_MODE  (LOW_MODE),
    .STOP_DLY  (STOP_DLY),
    .DOZE_DLY  (DOZE_DLY),
    .SLEEP_DLY (SLEEP_DLY),
    .UPD_DLY   (UPD_DLY)
  ) u_fsm (
    .clk     (clk_ctl),
    .rst_n   (rst_n),
    .pin_lvl (pin_lvl),
    .ack_v   (ack_v),
    .en_req  (en_req),
    .oe      (oe_o),
    .mode    (mode_q),
    .sel     (sel_o),
    .busy    (busy_o)
  );

  assign clk_o  = |gclk_v;
  assign mode_o = mode_q;
  assign pd_o   = power_flags(mode_q);
endmodule

// File: rtl/clksel_ctrl_chk.sv
`timescale 1ns/1ps
module clksel_ctrl_chk #(
  parameter int FREQS    = 2,
  parameter int BUSY_MAX = 400
) (
  input logic             clk_ctl,
  input logic             rst_n,
  input logic             clk_o,
  input logic             oe_o,
  input logic [2:0]       pd_o,
  input logic [1:0]       mode_o,
  input logic [1:0]       sel_o,
  input logic             busy_o,
  input logic [FREQS-1:0] gate_on
);
  logic [15:0] run_q;

  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 16'd1;
    else             run_q <= '0;
  end

  // R4
  always_comb begin
    if (rst_n === 1'b1 && oe_o === 1'b0)
      quiet_when_off_chk: assert (clk_o == 1'b0);
  end

  // R4
  closed_before_off_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $fell(oe_o) |-> (gate_on == '0) && (mode_o != 2'd0));

  // R9
  single_gate_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $onehot0(gate_on));

  // R9
  busy_bound_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    run_q <= 16'(BUSY_MAX));

  // R10
  sel_hold_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(sel_o));

  // R11
  awake_when_on_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    oe_o |-> (pd_o == 3'b000) && (mode_o == 2'd0));

  // R2
  quad_stays_on_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $fell(oe_o) |-> (FREQS != 4));
endmodule

bind clksel_ctrl clksel_ctrl_chk #(
  .FREQS    (FREQS),
  .BUSY_MAX (SLEEP_DLY + UPD_DLY + 256)
) u_chk (
  .clk_ctl (clk_ctl),
  .rst_n   (rst_n),
  .clk_o   (clk_o),
  .oe_o    (oe_o),
  .pd_o    (pd_o),
  .mode_o  (mode_o),
  .sel_o   (sel_o),
  .busy_o  (busy_o),
  .gate_on (gate_on)
);

// File: tb/test_clksel_ctrl.sv
`timescale 1ns/1ps
module test_clksel_ctrl;
  import clksel_pkg::*;

  localparam int STOP_D  = 2;
  localparam int DOZE_D  = 40;
  localparam int SLEEP_D = 80;
  localparam int UPD_D   = 8;
  localparam int WIN_NS  = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pin = 2'b10, qpin = 2'b10;
  logic [3:0] src = 4'b0000;

  always #10 clk = ~clk;
  always #12 src[0] = ~src[0];
  always #20 src[1] = ~src[1];
  always #28 src[2] = ~src[2];
  always #36 src[3] = ~src[3];

  logic a_clk, a_oe, a_busy, b_clk, b_oe, b_busy, q_clk, q_oe, q_busy;
  logic [2:0] a_pd, b_pd, q_pd;
  logic [1:0] a_mode, b_mode, q_mode, a_sel, b_sel, q_sel;
  wire a_pad = a_oe ? a_clk : 1'bz;

  clksel_ctrl #(.FREQS(2), .LOW_MODE(PM_STOP), .STOP_DLY(STOP_D), .DOZE_DLY(DOZE_D),
                .SLEEP_DLY(SLEEP_D), .UPD_DLY(UPD_D)) i_clksel_ctrl (
    .clk_ctl(clk), .rst_n(rst_n), .pin_lvl(pin), .src_clk(src[1:0]), .clk_o(a_clk),
    .oe_o(a_oe), .pd_o(a_pd), .mode_o(a_mode), .sel_o(a_sel), .busy_o(a_busy));

  clksel_ctrl #(.FREQS(2), .LOW_MODE(PM_DOZE), .STOP_DLY(STOP_D), .DOZE_DLY(DOZE_D),
                .SLEEP_DLY(SLEEP_D), .UPD_DLY(UPD_D)) i_clksel_ctrl_dz (
    .clk_ctl(clk), .rst_n(rst_n), .pin_lvl(pin), .src_clk(src[1:0]), .clk_o(b_clk),
    .oe_o(b_oe), .pd_o(b_pd), .mode_o(b_mode), .sel_o(b_sel), .busy_o(b_busy));

  clksel_ctrl #(.FREQS(4), .LOW_MODE(PM_STOP), .STOP_DLY(STOP_D), .DOZE_DLY(DOZE_D),
                .SLEEP_DLY(SLEEP_D), .UPD_DLY(UPD_D)) i_clksel_ctrl_qd (
    .clk_ctl(clk), .rst_n(rst_n), .pin_lvl(qpin), .src_clk(src), .clk_o(q_clk),
    .oe_o(q_oe), .pd_o(q_pd), .mode_o(q_mode), .sel_o(q_sel), .busy_o(q_busy));

  int checks = 0, errors = 0;
  int a_edges = 0, b_edges = 0, q_edges = 0, runts = 0;
  real a_r = -1.0e6, a_f = -1.0e6, b_r = -1.0e6, b_f = -1.0e6, q_r = -1.0e6, q_f = -1.0e6;

  // edge counting and phase-width monitor (R4, R9)
  always @(posedge a_clk) begin a_edges++; if ($realtime - a_f < 11.5) runts++; a_r = $realtime; end
  always @(negedge a_clk) begin if ($realtime - a_r < 11.5) runts++; a_f = $realtime; end
  always @(posedge b_clk) begin b_edges++; if ($realtime - b_f < 11.5) runts++; b_r = $realtime; end
  always @(negedge b_clk) begin if ($realtime - b_r < 11.5) runts++; b_f = $realtime; end
  always @(posedge q_clk) begin q_edges++; if ($realtime - q_f < 11.5) runts++; q_r = $realtime; end
  always @(negedge q_clk) begin if ($realtime - q_r < 11.5) runts++; q_f = $realtime; end

  typedef struct packed {
    logic [1:0] pin;
    logic       a_on;
    logic [1:0] sel;
    logic [1:0] a_mode;
    logic       b_on;
    logic [1:0] b_mode;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'b10, 1'b1, 2'd1, 2'd0, 1'b1, 2'd0},
    '{2'b11, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0},
    '{2'b00, 1'b0, 2'd0, 2'd1, 1'b0, 2'd2},
    '{2'b11, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0},
    '{2'b10, 1'b1, 2'd1, 2'd0, 1'b1, 2'd0},
    '{2'b01, 1'b0, 2'd1, 2'd1, 1'b0, 2'd2},
    '{2'b11, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0}
  };

  function automatic int flags_for(input logic [1:0] m);
    case (m)
      2'd1: return 1;
      2'd2: return 3;
      2'd3: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int edges_for(input logic [1:0] s);
    return WIN_NS / (24 + 16 * int'(s));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input int exp);
    checks++;
    if (act < exp - 2 || act > exp + 2) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    @(posedge clk);
    @(negedge clk);
    while ((a_busy || b_busy || q_busy) && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 20000) chk(req, "busy timeout", 1, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(output int da, output int db, output int dq);
    int sa, sb, sq;
    sa = a_edges; sb = b_edges; sq = q_edges;
    #(WIN_NS);
    da = a_edges - sa; db = b_edges - sb; dq = q_edges - sq;
    @(negedge clk);
  endtask

  // edges until oe rises, counting the sampling edge as 1
  task automatic count_resume(output int na, output int nb, output int nq,
                              output logic [1:0] sa, output logic [1:0] sb);
    na = 0; nb = 0; nq = 0; sa = 2'd0; sb = 2'd0;
    for (int n = 1; n < 1000; n++) begin
      @(posedge clk);
      #1;
      if (a_oe && na == 0) begin na = n; sa = a_sel; end
      if (b_oe && nb == 0) begin nb = n; sb = b_sel; end
      if (q_oe && nq == 0) nq = n;
      if (na != 0 && nb != 0 && nq != 0) break;
    end
  endtask

  initial begin
    #(150000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int na, nb, nq, da, db, dq;
    logic [1:0] sa, sb;

    repeat (5) @(negedge clk);
    // R3 reset state
    chk("R3", "reset oe", int'(a_oe), 0);
    chk("R3", "reset busy", int'(a_busy), 0);
    chk("R3", "reset mode", int'(a_mode), 3);
    chk("R3", "reset pd", int'(a_pd), 7);
    chk("R3", "reset sel", int'(a_sel), 1);
    chk("R4", "reset pad hi-z", int'(a_pad === 1'bz), 1);
    chk("R4", "reset clk low", int'(a_clk), 0);

    rst_n = 1'b1;
    count_resume(na, nb, nq, sa, sb);
    chk("R3", "startup edges a", na, SLEEP_D + 2);
    chk("R3", "startup edges q", nq, SLEEP_D + 2);
    chk("R3", "startup default sel", int'(sa), 1);
    wait_idle("R3");
    chk("R3", "quad default sel", int'(q_sel), 1);

    // table walk (R1, R5, R6, R9, R11)
    for (int v = 0; v < 7; v++) begin
      pin = VEC[v].pin;
      wait_idle("R1");
      measure(da, db, dq);
      chk("R1", $sformatf("vec %0d oe a", v), int'(a_oe), int'(VEC[v].a_on));
      chk("R1", $sformatf("vec %0d oe b", v), int'(b_oe), int'(VEC[v].b_on));
      chk("R1", $sformatf("vec %0d sel a", v), int'(a_sel), int'(VEC[v].sel));
      chk("R5", $sformatf("vec %0d mode a", v), int'(a_mode), int'(VEC[v].a_mode));
      chk("R6", $sformatf("vec %0d mode b", v), int'(b_mode), int'(VEC[v].b_mode));
      chk("R11", $sformatf("vec %0d pd a", v), int'(a_pd), flags_for(VEC[v].a_mode));
      chk("R6", $sformatf("vec %0d pd b", v), int'(b_pd), flags_for(VEC[v].b_mode));
      chk_near("R9", $sformatf("vec %0d edges a", v), da, VEC[v].a_on ? edges_for(VEC[v].sel) : 0);
      chk_near("R9", $sformatf("vec %0d edges b", v), db, VEC[v].b_on ? edges_for(VEC[v].sel) : 0);
      if (!VEC[v].a_on) chk("R4", "pad hi-z when off", int'(a_pad === 1'bz), 1);
    end

    // R5 / R6 resume delays, same selection
    pin = 2'b00;
    wait_idle("R5");
    pin = 2'b11;
    count_resume(na, nb, nq, sa, sb);
    chk("R5", "stop resume edges", na, STOP_D + 2);
    chk("R6", "doze resume edges", nb, DOZE_D + 2);
    wait_idle("R5");

    // R7 / R8 selection change while off
    pin = 2'b00;
    wait_idle("R7");
    pin = 2'b10;
    count_resume(na, nb, nq, sa, sb);
    chk("R7", "stop resumes on old sel", int'(sa), 0);
    chk("R8", "doze resumes on new sel", int'(sb), 1);
    wait_idle("R7");
    measure(da, db, dq);
    chk("R7", "stop final sel", int'(a_sel), 1);
    chk_near("R7", "stop final edges", da, edges_for(2'd1));
    chk_near("R8", "doze edges", db, edges_for(2'd1));

    // R10 requests ignored while busy
    pin = 2'b11;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9", "busy during switch", int'(a_busy), 1);
    pin = 2'b00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "oe held while busy", int'(a_oe & b_oe), 1);
    end
    pin = 2'b11;
    wait_idle("R10");
    chk("R10", "oe after ignored low", int'(a_oe & b_oe), 1);
    chk("R10", "mode after ignored low", int'(a_mode | b_mode), 0);
    chk("R10", "sel after ignored low", int'(a_sel), 0);
    chk("R10", "no late busy", int'(a_busy | b_busy), 0);

    // R2 four-frequency mapping
    for (int l = 3; l >= 0; l--) begin
      qpin = 2'(l);
      wait_idle("R2");
      measure(da, db, dq);
      chk("R2", $sformatf("quad lvl %0d sel", l), int'(q_sel), 3 - l);
      chk("R2", $sformatf("quad lvl %0d oe", l), int'(q_oe), 1);
      chk("R2", $sformatf("quad lvl %0d mode", l), int'(q_mode), 0);
      chk_near("R2", $sformatf("quad lvl %0d edges", l), dq, edges_for(2'(3 - l)));
    end

    chk("R4", "runt pulses", runts, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule